// File: doc/BRIEF.md
# Stereo Serial Audio Transmit Master

This block drives the transmit side of a two-channel serial audio link as the clock master. From a system clock and an 8-bit divider value N it produces a bit clock and a word strobe, and shifts out a 16-bit left word followed by a 16-bit right word on a single data line. Each stereo frame lasts 64 × (N + 1) system clocks. A single-cycle interrupt pulse marks a chosen point in the frame, so that software can refill the two transmit words once per sample.

Software uses a simple write port with four targets: the divider, the mode, and the left and right transmit words. The two words are double-buffered: a write lands in a holding register and is only copied into the output shifter at the start of that channel's word. A status output gives the current strobe phase. Writing the divider restarts the frame from its beginning. Clearing the master-enable mode bit stops the port and parks every output low.

The timing core is a three-state machine. `ST_OFF` is the parked state. `ST_LEFT` covers the first 32 half bit-clock periods of a frame, when the strobe is low. `ST_RIGHT` covers the last 32, when the strobe is high. The transitions are as follows:
- *enable*: `ST_OFF` to `ST_LEFT`, when the master-enable bit is written to 1.
- *mid-frame*: `ST_LEFT` to `ST_RIGHT`, on entering half-period 32.
- *wrap*: `ST_RIGHT` to `ST_LEFT`, on entering half-period 0.
- *restart*: any running state to `ST_LEFT`, on a divider write.
- *disable*: any state to `ST_OFF`, when the master-enable bit is written to 0.

Top module: `i2s_tx_master`

## Requirements
- R1: After reset N is 8 and the mode is 0. `sclk_o`, `ws_o`, `sd_o`, `irq_o` and `status_o` are all 0.
- R2: A divider write (`wr_sel` = 0) keeps only `wr_data[7:0]` as N. While the port is enabled, each half period of the bit clock lasts N + 1 system clocks. `sclk_o` is low in the first half period after enable or restart, and then alternates.
- R3: A frame is 64 half periods. The strobe phase is low (left) for half periods 0 to 31 and high (right) for half periods 32 to 63. `status_o[0]` is the strobe phase and `status_o[1]` is 1 while the left channel is current. Both bits are 0 when the port is disabled.
- R4: Mode bit 2 gates the strobe onto `ws_o`. When bit 2 is 0, `ws_o` stays 0 and `status_o` still follows the phase.
- R5: Data changes only when the bit clock falls, and is sent MSB first. Bit period b (= half period / 2) carries the left word's bit 16 − b for b in 1..16, the right word's bit 32 − b for b in 17..31, and the previous right word's bit 0 for b = 0. This bit is 0 until a right word has been loaded.
- R6: A left write (`wr_sel` = 2) or right write (`wr_sel` = 3) goes to a holding register. The holding value is copied into the shifter on entering bit period 1 (left) or 17 (right), so a later write does not change the word being sent.
- R7: Mode bit 4 raises `irq_o` on entering half period 0 (strobe falling), and mode bit 3 on entering half period 32 (strobe rising). With both set, two pulses come per frame.
- R8: Mode bit 5 raises `irq_o` on entering half periods 2 and 34, the MSB of each word. Every interrupt is a single-cycle pulse.
- R9: A divider write restarts the frame at half period 0 with an empty shifter, and suppresses any interrupt in that cycle.
- R10: Mode bit 0 is master enable (`wr_sel` = 1, `wr_data[5:0]` is the mode). After a write that clears it, every output is 0 and no interrupt is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 divider, 1 mode, 2 left word, 3 right word |
| wr_data | input | 16 | Write data |
| sclk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word strobe, low for left and high for right |
| sd_o | output | 1 | Serial data, MSB first |
| irq_o | output | 1 | Sample interrupt pulse |
| status_o | output | 2 | Bit 0 is the strobe phase, bit 1 is the left-channel flag |

## Verification
The port is run with the reset divider and with divider 0. With divider 0, each half period is a single clock, which separates an off-by-one in the half-period count from a correct wrap. The words carry alternating and asymmetric bit patterns, so a reversed shift order, a missed load or a swapped channel each show up on `sd_o`. The interrupt modes are tried alone and together, and with the strobe output gated off, which tells the edge choice apart from the strobe drive. Word rewrites mid-word, a restart mid-frame, and a disable/re-enable with a divider above 8 bits show whether the buffering, the restart and the parking hold.

// File: rtl/i2s_mst_pkg.sv
package i2s_mst_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } frame_st_t;

    localparam logic [1:0] SEL_DIV   = 2'd0;
    localparam logic [1:0] SEL_MODE  = 2'd1;
    localparam logic [1:0] SEL_LEFT  = 2'd2;
    localparam logic [1:0] SEL_RIGHT = 2'd3;

    localparam int MB_ENABLE = 0;
    localparam int MB_WSEN   = 2;
    localparam int MB_RISE   = 3;
    localparam int MB_FALL   = 4;
    localparam int MB_MSB    = 5;

endpackage

// File: rtl/i2s_bitclk_gen.sv
module i2s_bitclk_gen #(
    parameter int DIV_W  = 8,
    parameter int HALF_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_q,
    input  logic              restart,
    input  logic [DIV_W-1:0]  div_q,
    output logic [HALF_W-1:0] half_q,
    output logic              step
);

    logic [DIV_W-1:0] cnt_q;

    assign step = en_q && (cnt_q == div_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            half_q <= '0;
        end else if (restart || !en_q) begin
            cnt_q  <= '0;
            half_q <= '0;
        end else if (step) begin
            cnt_q  <= '0;
            half_q <= half_q + 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R2: the prescale count never passes the divider value
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= div_q);

    // R10: a parked port keeps its timing at the frame origin
    a_r10_parked_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !restart) |=> (half_q == '0));

endmodule

// File: rtl/i2s_frame_fsm.sv
module i2s_frame_fsm
    import i2s_mst_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int HALF_W = 6,
    parameter int MODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_q,
    input  logic              en_next,
    input  logic              restart,
    input  logic              step,
    input  logic [HALF_W-1:0] half_q,
    input  logic [MODE_W-1:0] mode_q,
    output frame_st_t         state_q,
    output logic              irq_q
);

    localparam logic [HALF_W-1:0] HALF_MID  = HALF_W'(2 * WORD_W);
    localparam logic [HALF_W-1:0] HALF_LMSB = HALF_W'(2);
    localparam logic [HALF_W-1:0] HALF_RMSB = HALF_W'(2 * WORD_W + 2);

    frame_st_t         state_d;
    logic [HALF_W-1:0] half_nx;
    logic              ev_fall, ev_rise, ev_msb, irq_d;

    assign half_nx = half_q + 1'b1;
    assign ev_fall = (half_nx == '0);
    assign ev_rise = (half_nx == HALF_MID);
    assign ev_msb  = (half_nx == HALF_LMSB) || (half_nx == HALF_RMSB);

    always_comb begin
        state_d = state_q;
        if (!en_next) begin
            state_d = ST_OFF;
        end else if (restart) begin
            state_d = ST_LEFT;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_LEFT;
                ST_LEFT:  if (step && ev_rise) state_d = ST_RIGHT;
                ST_RIGHT: if (step && ev_fall) state_d = ST_LEFT;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_d = en_q && step && !restart &&
                ((ev_fall && mode_q[MB_FALL]) ||
                 (ev_rise && mode_q[MB_RISE]) ||
                 (ev_msb  && mode_q[MB_MSB]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    // R3: the running state agrees with the half-period counter's upper bit
    a_r3_phase_match: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF) |-> ((state_q == ST_RIGHT) == half_q[HALF_W-1]));

    // R10: nothing is raised once master mode is off
    a_r10_no_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !irq_q);

    // R9: a restart leaves the frame at its origin in the left slot
    a_r9_restart_left: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && en_next) |=> (state_q == ST_LEFT && half_q == '0));

endmodule

// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter #(
    parameter int WORD_W = 16,
    parameter int HALF_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_q,
    input  logic              restart,
    input  logic              step,
    input  logic [HALF_W-1:0] half_q,
    input  logic              wr_left,
    input  logic              wr_right,
    input  logic [WORD_W-1:0] wr_word,
    output logic              sd_bit
);

    localparam logic [HALF_W-1:0] HALF_LMSB = HALF_W'(2);
    localparam logic [HALF_W-1:0] HALF_RMSB = HALF_W'(2 * WORD_W + 2);

    logic [WORD_W-1:0] lbuf_q, rbuf_q, sh_q;
    logic [HALF_W-1:0] half_nx;
    logic              fall_edge, load_l, load_r;

    assign half_nx   = half_q + 1'b1;
    assign fall_edge = step && half_q[0];
    assign load_l    = fall_edge && (half_nx == HALF_LMSB);
    assign load_r    = fall_edge && (half_nx == HALF_RMSB);
    assign sd_bit    = sh_q[WORD_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lbuf_q <= '0;
            rbuf_q <= '0;
        end else begin
            if (wr_left)  lbuf_q <= wr_word;
            if (wr_right) rbuf_q <= wr_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (!en_q || restart) begin
            sh_q <= '0;
        end else if (load_l) begin
            sh_q <= lbuf_q;
        end else if (load_r) begin
            sh_q <= rbuf_q;
        end else if (fall_edge) begin
            sh_q <= {sh_q[WORD_W-2:0], 1'b0};
        end
    end

    // R6: the left word enters the shifter from its holding register
    a_r6_left_load: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !restart && load_l) |=> (sh_q == $past(lbuf_q)));

    // R5: with no falling edge, the output bit holds
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !restart && !fall_edge) |=> $stable(sh_q));

endmodule

// File: rtl/i2s_tx_master.sv
module i2s_tx_master
    import i2s_mst_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int WORD_W  = 16,
    parameter int MODE_W  = 6,
    parameter int DIV_RST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic              sclk_o,
    output logic              ws_o,
    output logic              sd_o,
    output logic              irq_o,
    output logic [1:0]        status_o
);

    localparam int HALF_W = $clog2(4 * WORD_W);

    logic [DIV_W-1:0]  div_q;
    logic [MODE_W-1:0] mode_q;
    logic [HALF_W-1:0] half_q;
    logic              restart, en_next, step, sd_bit, running;
    frame_st_t         state_q;

    assign restart = wr_en && (wr_sel == SEL_DIV);
    assign en_next = (wr_en && (wr_sel == SEL_MODE)) ? wr_data[MB_ENABLE]
                                                     : mode_q[MB_ENABLE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= DIV_W'(DIV_RST);
            mode_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_DIV)  div_q  <= wr_data[DIV_W-1:0];
            if (wr_sel == SEL_MODE) mode_q <= wr_data[MODE_W-1:0];
        end
    end

    i2s_bitclk_gen #(.DIV_W(DIV_W), .HALF_W(HALF_W)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_q    (mode_q[MB_ENABLE]),
        .restart (restart),
        .div_q   (div_q),
        .half_q  (half_q),
        .step    (step)
    );

    i2s_frame_fsm #(.WORD_W(WORD_W), .HALF_W(HALF_W), .MODE_W(MODE_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_q    (mode_q[MB_ENABLE]),
        .en_next (en_next),
        .restart (restart),
        .step    (step),
        .half_q  (half_q),
        .mode_q  (mode_q),
        .state_q (state_q),
        .irq_q   (irq_o)
    );

    i2s_tx_shifter #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_q     (mode_q[MB_ENABLE]),
        .restart  (restart),
        .step     (step),
        .half_q   (half_q),
        .wr_left  (wr_en && (wr_sel == SEL_LEFT)),
        .wr_right (wr_en && (wr_sel == SEL_RIGHT)),
        .wr_word  (wr_data),
        .sd_bit   (sd_bit)
    );

    assign running     = (state_q != ST_OFF);
    assign sclk_o      = running && half_q[0];
    assign ws_o        = mode_q[MB_WSEN] && (state_q == ST_RIGHT);
    assign sd_o        = running && sd_bit;
    assign status_o[0] = (state_q == ST_RIGHT);
    assign status_o[1] = (state_q == ST_LEFT);

    // R8: every interrupt is one clock wide
    a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R4: the strobe pin never shows while its enable bit is clear
    a_r4_ws_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[MB_WSEN] |-> !ws_o);

    // R3: exactly one channel flag while running, none while parked
    a_r3_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status_o) && (running == (status_o != 2'b00)));

endmodule

// File: tb/i2s_tx_master_tb_top.sv
module i2s_tx_master_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        sclk_o, ws_o, sd_o, irq_o;
    logic [1:0]  status_o;

    int    checks = 0;
    int    errors = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string phase = "R1";

    // behavioural model state
    int          m_n = 8;
    logic [5:0]  m_mode = '0;
    int          m_t = 0;
    logic [15:0] m_lb = '0, m_rb = '0, m_lw = '0, m_rw = '0;
    logic        m_irq = 1'b0;

    always #10 clk = ~clk;

    i2s_tx_master dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .sclk_o   (sclk_o),
        .ws_o     (ws_o),
        .sd_o     (sd_o),
        .irq_o    (irq_o),
        .status_o (status_o)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_n = 8; m_mode = '0; m_t = 0;
            m_lb = '0; m_rb = '0; m_lw = '0; m_rw = '0; m_irq = 1'b0;
        end else begin
            m_irq = 1'b0;
            if (m_mode[0]) begin
                m_t++;
                if (m_t % (m_n + 1) == 0) begin
                    int hh;
                    hh = (m_t / (m_n + 1)) % 64;
                    if (hh == 2)  m_lw = m_lb;
                    if (hh == 34) m_rw = m_rb;
                    if ((hh == 0 && m_mode[4]) || (hh == 32 && m_mode[3]) ||
                        ((hh == 2 || hh == 34) && m_mode[5]))
                        m_irq = 1'b1;
                end
            end
            if (wr_en) begin
                case (wr_sel)
                    2'd0: begin
                        m_n = int'(wr_data[7:0]); m_t = 0;
                        m_lw = '0; m_rw = '0; m_irq = 1'b0;
                    end
                    2'd1: begin
                        m_mode = wr_data[5:0];
                        if (!wr_data[0]) begin m_t = 0; m_lw = '0; m_rw = '0; end
                    end
                    2'd2: m_lb = wr_data;
                    default: m_rb = wr_data;
                endcase
            end
        end
    end

    task automatic chk(input string req, input string sig, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s/%s %s actual=%0b expected=%0b at %0t", phase, req, sig, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            int   hh, b;
            logic act, e_sd;
            act = m_mode[0];
            hh  = (m_t / (m_n + 1)) % 64;
            b   = hh / 2;
            if (b == 0)       e_sd = m_rw[0];
            else if (b <= 16) e_sd = m_lw[16 - b];
            else              e_sd = m_rw[32 - b];
            chk("R2", "sclk_o", sclk_o, act && (hh % 2 == 1));
            chk("R4", "ws_o", ws_o, act && m_mode[2] && hh >= 32);
            chk("R3", "status0", status_o[0], act && hh >= 32);
            chk("R3", "status1", status_o[1], act && hh < 32);
            chk("R5", "sd_o", sd_o, act && e_sd);
            chk("R7", "irq_o", irq_o, m_irq);
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        cmp_on = 1'b1;
        phase = "R1";
        idle(3);
        rst_n = 1'b1;
        idle(4);

        phase = "R5";
        wr(2'd2, 16'hA5C3);
        wr(2'd3, 16'h3C5A);
        wr(2'd1, 16'h003D);
        idle(1300);

        phase = "R2";
        wr(2'd0, 16'h0100);
        wr(2'd2, 16'h8001);
        wr(2'd3, 16'h7FFE);
        idle(300);

        phase = "R4";
        wr(2'd1, 16'h0009);
        idle(200);

        phase = "R7";
        wr(2'd1, 16'h0015);
        wr(2'd0, 16'h0002);
        idle(600);

        phase = "R6";
        for (int i = 0; i < 20; i++) begin
            wr(2'd2, 16'h1111 * 16'(i));
            idle(17);
            wr(2'd3, 16'hF0F0 ^ 16'(i * 7));
            idle(23);
        end

        phase = "R8";
        wr(2'd1, 16'h0021);
        idle(500);

        phase = "R9";
        wr(2'd0, 16'h0005);
        idle(150);
        wr(2'd0, 16'h0001);
        idle(200);

        phase = "R10";
        wr(2'd1, 16'h0038);
        idle(300);
        wr(2'd0, 16'h0004);
        idle(50);

        phase = "R2";
        wr(2'd1, 16'h003D);
        wr(2'd0, 16'h0203);
        idle(700);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule